// File: doc/BRIEF.md
# Fractional UART Bit Timing Generator

This block produces the bit timing for UART frames on two independent channels, one for transmit and one for receive. A shared integer divisor turns the system clock into sub-ticks. A nominal bit spans sixteen sub-ticks. Each channel also has its own per-bit adjustment word that can make any single bit position one sub-tick longer or shorter. Spreading these small corrections across the frame keeps the total frame duration close to the ideal rate, with no fractional accumulator.

A serializer or sampler sits beside each channel. It pulses that channel's start input at the beginning of a frame. It then uses the sub-tick strobe for oversampling, the bit-end strobe to advance its shift register, and the bit index to know which field it is in. The divisor, the adjustment word and the frame format are all captured at the start pulse. The captured values govern the whole frame, whatever happens on the inputs afterwards.

Top module: `uart_jitter_baudgen`

## Requirements
- R1: After reset, both channels are idle: busy 0, sub-tick 0, bit-end 0 and bit index 0.
- R2: While a channel is busy, its sub-tick strobe pulses once every N clocks, where N = div_i + 1. The first pulse comes in the N-th cycle after the clock edge that captured the start pulse.
- R3: A bit whose adjustment code is 00 or 11 lasts 16 sub-ticks. The bit-end strobe is high together with the sub-tick that closes the bit.
- R4: The 2-bit code for bit position k is at bits 2k+1:2k of the channel's adjustment word. Code 01 stretches that bit to 17 sub-ticks, and code 10 shrinks it to 15.
- R5: The frame holds 1 start bit, then 5 + data_bits_i data bits, then one parity bit if parity_en_i is set, then one stop bit, or two if two_stop_i is set. That gives 7 to 12 bits. Busy falls right after the bit-end of the last bit, and the idle bit index is 0.
- R6: The bit index is 0 for the first bit and increases by one after each bit-end.
- R7: A start pulse restarts the channel at bit 0 with fresh timing, even in the middle of a frame.
- R8: Changes to the divisor, the adjustment words or the format during a frame have no effect until the next start pulse on that channel.
- R9: The two channels run independently. Each has its own start and its own adjustment word, and both use the same divisor input.
- R10: An idle channel produces no sub-tick and no bit-end pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Divisor minus one (clocks per sub-tick minus one) |
| data_bits_i | input | 2 | Data bit count minus five |
| parity_en_i | input | 1 | Frame carries a parity bit |
| two_stop_i | input | 1 | Frame carries two stop bits |
| tx_jit_i | input | 2*MAX_BITS | Transmit per-bit adjustment word |
| rx_jit_i | input | 2*MAX_BITS | Receive per-bit adjustment word |
| tx_start_i | input | 1 | Start a transmit frame |
| rx_start_i | input | 1 | Start a receive frame |
| tx_tick_o | output | 1 | Transmit sub-tick strobe |
| tx_bit_end_o | output | 1 | Transmit bit-boundary strobe |
| tx_bit_idx_o | output | IDX_W | Transmit current bit index |
| tx_busy_o | output | 1 | Transmit frame in progress |
| rx_tick_o | output | 1 | Receive sub-tick strobe |
| rx_bit_end_o | output | 1 | Receive bit-boundary strobe |
| rx_bit_idx_o | output | IDX_W | Receive current bit index |
| rx_busy_o | output | 1 | Receive frame in progress |

## Verification
The bench counts cycle j from the edge that captures a start pulse, so j is 0 in the first cycle after that edge. In cycle j the channel is busy, the sub-tick pulses when (j+1) is a multiple of N, and bit k ends at j = N·(L0+…+Lk) − 1, where Li is the sub-tick length of bit i. The bench's reference function computes these figures from the values the bench itself drove when it issued the start. Every output of both channels is compared on each falling edge against that schedule. Restarts and input changes made in the middle of a frame are modelled in the same cycle-exact way.

// File: rtl/uart_jbg_pkg.sv
package uart_jbg_pkg;
  typedef enum logic [1:0] {
    JIT_NOM = 2'b00,
    JIT_INC = 2'b01,
    JIT_DEC = 2'b10,
    JIT_RSV = 2'b11
  } jit_code_e;

  localparam int SUB_PER_BIT = 16;
  localparam int MIN_FRAME   = 7;

  // signed sub-tick adjustment for one bit position
  function automatic int jit_adj(input logic [1:0] code);
    case (jit_code_e'(code))
      JIT_INC: return 1;
      JIT_DEC: return -1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/uart_frame_len.sv
module uart_frame_len #(
  parameter int LEN_W = 4
) (
  input  logic [1:0]       data_bits_i,
  input  logic             parity_en_i,
  input  logic             two_stop_i,
  output logic [LEN_W-1:0] len_o
);
  import uart_jbg_pkg::*;

  always_comb begin
    len_o = LEN_W'(MIN_FRAME) + LEN_W'(data_bits_i)
          + LEN_W'(parity_en_i) + LEN_W'(two_stop_i);
  end
endmodule

// File: rtl/uart_subtick_div.sv
module uart_subtick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else if (en_i)     cnt_q <= cnt_q + 1'b1;
  end

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q <= div_i);
endmodule

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
  parameter int DIV_W    = 8,
  parameter int MAX_BITS = 12,
  localparam int IDX_W   = $clog2(MAX_BITS),
  localparam int LEN_W   = $clog2(MAX_BITS + 1),
  localparam int JIT_W   = 2 * MAX_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [JIT_W-1:0] jit_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             tick_o,
  output logic             bit_end_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             busy_o
);
  import uart_jbg_pkg::*;
  localparam int SUB_W = $clog2(SUB_PER_BIT + 2);

  logic             busy_q;
  logic [DIV_W-1:0] div_q;
  logic [JIT_W-1:0] jit_q;
  logic [LEN_W-1:0] len_q;
  logic [SUB_W-1:0] sub_q;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       code;
  logic [SUB_W-1:0] last_sub;
  logic             last_bit;

  uart_subtick_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .en_i   (busy_q),
    .div_i  (div_q),
    .tick_o (tick_o)
  );

  always_comb begin
    code      = jit_q[{idx_q, 1'b0} +: 2];
    last_sub  = SUB_W'(SUB_PER_BIT - 1 + jit_adj(code));
    bit_end_o = tick_o && (sub_q == last_sub);
    last_bit  = (LEN_W'(idx_q) == len_q - LEN_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      div_q  <= '0;
      jit_q  <= '0;
      len_q  <= '0;
      sub_q  <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      div_q  <= div_i;
      jit_q  <= jit_i;
      len_q  <= len_i;
      sub_q  <= '0;
      idx_q  <= '0;
    end else if (tick_o) begin
      if (bit_end_o) begin
        sub_q <= '0;
        if (last_bit) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign bit_idx_o = idx_q;
  assign busy_o    = busy_q;

  a_r7_start_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q && idx_q == '0 && sub_q == '0);
  a_r8_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !start_i |=> $stable(div_q) && $stable(jit_q) && $stable(len_q));
  a_r6_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_end_o && !last_bit && !start_i |=> idx_q == $past(idx_q) + 1'b1);
  a_r5_idx_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> LEN_W'(idx_q) < len_q);
  a_r4_bit_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_end_o |-> sub_q >= SUB_W'(SUB_PER_BIT - 2) && sub_q <= SUB_W'(SUB_PER_BIT));
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !bit_end_o && idx_q == '0);
endmodule

// File: rtl/uart_jitter_baudgen.sv
module uart_jitter_baudgen #(
  parameter int DIV_W    = 8,
  parameter int MAX_BITS = 12,
  localparam int IDX_W   = $clog2(MAX_BITS),
  localparam int JIT_W   = 2 * MAX_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic [1:0]       data_bits_i,
  input  logic             parity_en_i,
  input  logic             two_stop_i,
  input  logic [JIT_W-1:0] tx_jit_i,
  input  logic [JIT_W-1:0] rx_jit_i,
  input  logic             tx_start_i,
  input  logic             rx_start_i,
  output logic             tx_tick_o,
  output logic             tx_bit_end_o,
  output logic [IDX_W-1:0] tx_bit_idx_o,
  output logic             tx_busy_o,
  output logic             rx_tick_o,
  output logic             rx_bit_end_o,
  output logic [IDX_W-1:0] rx_bit_idx_o,
  output logic             rx_busy_o
);
  localparam int LEN_W = $clog2(MAX_BITS + 1);
  localparam int N_CH  = 2;

  logic [LEN_W-1:0] frame_len;
  logic             start_v [N_CH];
  logic [JIT_W-1:0] jit_v   [N_CH];
  logic             tick_v  [N_CH];
  logic             end_v   [N_CH];
  logic [IDX_W-1:0] idx_v   [N_CH];
  logic             busy_v  [N_CH];

  uart_frame_len #(.LEN_W(LEN_W)) u_len (
    .data_bits_i (data_bits_i),
    .parity_en_i (parity_en_i),
    .two_stop_i  (two_stop_i),
    .len_o       (frame_len)
  );

  assign start_v[0] = tx_start_i;
  assign start_v[1] = rx_start_i;
  assign jit_v[0]   = tx_jit_i;
  assign jit_v[1]   = rx_jit_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    uart_bit_timer #(.DIV_W(DIV_W), .MAX_BITS(MAX_BITS)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_v[c]),
      .div_i     (div_i),
      .jit_i     (jit_v[c]),
      .len_i     (frame_len),
      .tick_o    (tick_v[c]),
      .bit_end_o (end_v[c]),
      .bit_idx_o (idx_v[c]),
      .busy_o    (busy_v[c])
    );
  end

  assign tx_tick_o    = tick_v[0];
  assign tx_bit_end_o = end_v[0];
  assign tx_bit_idx_o = idx_v[0];
  assign tx_busy_o    = busy_v[0];
  assign rx_tick_o    = tick_v[1];
  assign rx_bit_end_o = end_v[1];
  assign rx_bit_idx_o = idx_v[1];
  assign rx_busy_o    = busy_v[1];
endmodule

// File: tb/tb_uart_jitter_baudgen.sv
module tb_uart_jitter_baudgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div = '0;
  logic [1:0]  dbits = '0;
  logic        par = 1'b0, stop2 = 1'b0;
  logic [23:0] tx_jit = '0, rx_jit = '0;
  logic        tx_start = 1'b0, rx_start = 1'b0;
  logic        tx_tick, tx_end, tx_busy, rx_tick, rx_end, rx_busy;
  logic [3:0]  tx_idx, rx_idx;

  always #10 clk = ~clk;

  uart_jitter_baudgen dut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .data_bits_i(dbits),
    .parity_en_i(par), .two_stop_i(stop2), .tx_jit_i(tx_jit), .rx_jit_i(rx_jit),
    .tx_start_i(tx_start), .rx_start_i(rx_start),
    .tx_tick_o(tx_tick), .tx_bit_end_o(tx_end), .tx_bit_idx_o(tx_idx), .tx_busy_o(tx_busy),
    .rx_tick_o(rx_tick), .rx_bit_end_o(rx_end), .rx_bit_idx_o(rx_idx), .rx_busy_o(rx_busy)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string ctx = "";

  // reference model state per channel (0 tx, 1 rx)
  int          m_n[2], m_len[2], m_j[2];
  logic [23:0] m_w[2];
  bit          m_act[2], m_pend[2], m_busy[2];

  task automatic check(string req, string what, int ch, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] ch%0d %s act=%0d exp=%0d", req, ctx, ch, what, act, exp);
    end
  endtask

  function automatic void ref_at(input int j, input int n, input logic [23:0] w,
                                 input int len, output bit eb, output bit et,
                                 output bit ee, output int ei);
    int t = 0;
    eb = 0; et = 0; ee = 0; ei = 0;
    for (int k = 0; k < len; k++) begin
      int l = 16;
      int e;
      if (w[2*k +: 2] == 2'b01) l = 17;
      else if (w[2*k +: 2] == 2'b10) l = 15;
      e = t + l * n - 1;
      if (j <= e) begin
        eb = 1; ei = k; ee = (j == e); et = ((j + 1) % n == 0);
        return;
      end
      t = t + l * n;
    end
  endfunction

  task automatic cyc();
    @(negedge clk);
    for (int ch = 0; ch < 2; ch++) begin
      bit eb, et, ee;
      int ei;
      if (m_pend[ch]) begin m_pend[ch] = 0; m_act[ch] = 1; m_j[ch] = 0; end
      else if (m_act[ch]) m_j[ch]++;
      if (m_act[ch]) ref_at(m_j[ch], m_n[ch], m_w[ch], m_len[ch], eb, et, ee, ei);
      else begin eb = 0; et = 0; ee = 0; ei = 0; end
      if (!eb) m_act[ch] = 0;
      m_busy[ch] = eb;
      check("R5", "busy", ch, int'(ch ? rx_busy : tx_busy), int'(eb));
      check("R6", "idx", ch, int'(ch ? rx_idx : tx_idx), ei);
      check(eb ? "R2" : "R10", "tick", ch, int'(ch ? rx_tick : tx_tick), int'(et));
      check(eb ? "R3/R4" : "R10", "bit_end", ch, int'(ch ? rx_end : tx_end), int'(ee));
    end
    tx_start = 0;
    rx_start = 0;
  endtask

  task automatic go(int ch);
    if (ch == 0) tx_start = 1; else rx_start = 1;
    m_pend[ch] = 1;
    m_n[ch]    = int'(div) + 1;
    m_w[ch]    = ch ? rx_jit : tx_jit;
    m_len[ch]  = 7 + int'(dbits) + int'(par) + int'(stop2);
  endtask

  task automatic wait_idle();
    int guard = 0;
    do begin cyc(); guard++; end
    while ((m_busy[0] || m_busy[1] || m_pend[0] || m_pend[1]) && guard < 5000);
    repeat (3) cyc();
  endtask

  initial begin
    #(64'd200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < 2; c++) begin m_act[c] = 0; m_pend[c] = 0; m_busy[c] = 0; end
    repeat (3) @(negedge clk);
    ctx = "R1 reset";
    check("R1", "busy", 0, int'(tx_busy), 0);
    check("R1", "busy", 1, int'(rx_busy), 0);
    check("R1", "tick", 0, int'(tx_tick | tx_end), 0);
    check("R1", "idx", 1, int'(rx_idx), 0);
    rst_n = 1;
    ctx = "R10 idle";
    repeat (5) cyc();

    ctx = "R3 nominal div0 8N1";
    div = 0; dbits = 3; tx_jit = '0; go(0); wait_idle();

    ctx = "R4 all increment div2 8E2";
    div = 2; par = 1; stop2 = 1; tx_jit = {12{2'b01}}; go(0); wait_idle();

    ctx = "R4 all decrement rx 5N1";
    div = 1; dbits = 0; par = 0; stop2 = 0; rx_jit = {12{2'b10}}; go(1); wait_idle();

    ctx = "R3 code 11 nominal";
    div = 3; dbits = 2; tx_jit = {12{2'b11}}; go(0); wait_idle();

    ctx = "R8 mid-frame change";
    div = 1; dbits = 1; tx_jit = 24'h000000; go(0);
    repeat (20) cyc();
    div = 4; dbits = 3; par = 1; stop2 = 1; tx_jit = 24'hAAAAAA;
    wait_idle();
    ctx = "R8 new values on next start";
    go(0); wait_idle();

    ctx = "R7 restart mid-frame";
    div = 0; dbits = 3; par = 0; stop2 = 0; tx_jit = 24'h155555; go(0);
    repeat (50) cyc();
    tx_jit = 24'h2A0041; go(0); wait_idle();

    ctx = "R9 both channels";
    div = 1; tx_jit = 24'h000555; rx_jit = 24'hAAA000; go(0); go(1);
    repeat (37) cyc();
    rx_jit = 24'h0; go(1);
    wait_idle();

    ctx = "R2 random frames";
    for (int it = 0; it < 24; it++) begin
      int mask;
      div = 8'($urandom % 6); dbits = 2'($urandom); par = 1'($urandom); stop2 = 1'($urandom);
      tx_jit = 24'($urandom); rx_jit = 24'($urandom);
      mask = 1 + ($urandom % 3);
      if (mask[0]) go(0);
      if (mask[1]) go(1);
      if ($urandom % 4 == 0) begin
        repeat (1 + $urandom % 200) cyc();
        div = 8'($urandom % 4); tx_jit = 24'($urandom);
        go(0);
      end
      wait_idle();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule